// File: doc/BRIEF.md
# 64-bit Integer ALU with Word Operations

This block is the integer execution unit of a 64-bit RISC-V style core. It is purely combinational. From two 64-bit operands and an operation select, it forms a 64-bit result within the same cycle. The select has three parts: the 3-bit function code, the alternate bit taken from bit 30 of the instruction, and a word-mode flag. The caller has already chosen operand B, either a register value or an immediate that is already sign-extended. The unit supports add, subtract, XOR, OR, AND, signed and unsigned set-less-than, left shift, and logical and arithmetic right shifts.

In word mode, add, subtract and the three shifts work on 32-bit quantities. Their 32-bit result is sign-extended from bit 31 to the full 64 bits. Word mode is defined only for those five operations. For any other function code, word mode yields a zero result and raises an illegal-operation flag.

Top module: `int_alu64`

## Requirements
- R1: Function code 000 with alternate bit 0 and word mode 0 gives A + B, wrapping modulo 2^64 with no overflow indication.
- R2: Function code 000 with alternate bit 1 and word mode 0 gives A - B, wrapping modulo 2^64.
- R3: Function code 100 gives A XOR B, 110 gives A OR B, and 111 gives A AND B, all over 64 bits.
- R4: Function code 010 gives exactly 1 when A is less than B as signed two's-complement values, and 0 otherwise. Bits 63..1 of the result are zero.
- R5: Function code 011 gives exactly 1 when A is less than B as unsigned values, and 0 otherwise.
- R6: Function code 001 without word mode shifts A left by B[5:0] and fills with zeros. Bits 63..6 of B have no effect.
- R7: Function code 101 without word mode shifts A right by B[5:0]. Alternate bit 0 fills with zeros, and alternate bit 1 fills with A[63].
- R8: In word mode, function code 000 computes the 32-bit sum (alternate 0) or difference (alternate 1) of A[31:0] and B[31:0]. The result is that value with bit 31 copied into bits 63..32.
- R9: In word mode, shifts use only B[4:0]. Left and logical right shifts act on A[31:0] with zero fill, and the arithmetic right shift fills from A[31]. The 32-bit result is then sign-extended from bit 31.
- R10: In word mode, function codes 010, 011, 100, 110 and 111 give a zero result with illegal_o = 1. In every other case illegal_o = 0.
- R11: The alternate bit has no effect on function codes 001, 010, 011, 100, 110 and 111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a_i | input | 64 | Operand A |
| op_b_i | input | 64 | Operand B (register or sign-extended immediate) |
| funct3_i | input | 3 | Function code |
| alt_i | input | 1 | Alternate bit: selects subtract or arithmetic shift |
| word_i | input | 1 | Word mode: 32-bit operation, result sign-extended |
| result_o | output | 64 | Result |
| illegal_o | output | 1 | Word mode requested for an operation without a word form |

## Verification
Two cases are hard to provoke with typical operands, so the stimulus targets each one directly.

The first is a word arithmetic right shift where A[31] and A[63] differ. Only in that case does filling from the wrong sign bit change the result. The bench therefore sweeps every shift amount from 0 to 63 with operands chosen so that the two bits disagree. It sets random upper bits in B, so that any unmasked shift-amount bit shows up in the result.

The second is the wrap of add and subtract at the most negative and most positive values. Directed operands cover these edges. A long random run then checks every operation against an independent model.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int ALU_XLEN = 64;
    localparam int ALU_WLEN = 32;

    typedef enum logic [2:0] {
        F3_ADD  = 3'b000,
        F3_SLL  = 3'b001,
        F3_SLT  = 3'b010,
        F3_SLTU = 3'b011,
        F3_XOR  = 3'b100,
        F3_SR   = 3'b101,
        F3_OR   = 3'b110,
        F3_AND  = 3'b111
    } alu_f3_e;

    typedef struct packed {
        logic [ALU_XLEN-1:0] res;
        logic                ill;
    } alu_out_t;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W  = 64,
    parameter int HW = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    input  logic         word_i,
    output logic [W-1:0] sum_o
);

    logic [W-1:0] sum_d;
    logic [W-1:0] b_eff_d;

    always_comb begin
        b_eff_d = sub_i ? ~b_i : b_i;
        sum_d   = a_i + b_eff_d + {{(W-1){1'b0}}, sub_i};
        sum_o   = word_i ? {{(W-HW){sum_d[HW-1]}}, sum_d[HW-1:0]} : sum_d;

        // Undoing the operation must give back operand A.
        if (!word_i && !sub_i) begin
            p_add_inverse_r1: assert (sum_d - b_i == a_i)
                else $error("add result does not invert");
        end
        if (!word_i && sub_i) begin
            p_sub_inverse_r2: assert (sum_d + b_i == a_i)
                else $error("sub result does not invert");
        end
    end

endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
    parameter int W   = 64,
    parameter int HW  = 32,
    localparam int SHW = $clog2(W)
) (
    input  logic [W-1:0]   src_i,
    input  logic [SHW-1:0] shamt_i,
    input  logic           left_i,
    input  logic           arith_i,
    input  logic           word_i,
    output logic [W-1:0]   dout_o
);

    function automatic logic [W-1:0] bit_rev(input logic [W-1:0] v);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) r[i] = v[W-1-i];
        return r;
    endfunction

    logic [SHW-1:0] sh_d;
    logic           fill_d;
    logic [W-1:0]   stage_d;
    logic [2*W-1:0] ext_d;
    logic [W-1:0]   raw_d;

    always_comb begin
        sh_d   = word_i ? {1'b0, shamt_i[SHW-2:0]} : shamt_i;
        fill_d = arith_i && !left_i && (word_i ? src_i[HW-1] : src_i[W-1]);
        if (left_i)      stage_d = bit_rev(src_i);
        else if (word_i) stage_d = {{(W-HW){fill_d}}, src_i[HW-1:0]};
        else             stage_d = src_i;

        // Logarithmic right-shift network: one stage per amount bit.
        for (int k = 0; k < SHW; k++) begin
            if (sh_d[k]) begin
                ext_d   = {{W{fill_d}}, stage_d} >> (1 << k);
                stage_d = ext_d[W-1:0];
            end
        end
        ext_d  = {{W{1'b0}}, stage_d};

        raw_d  = left_i ? bit_rev(stage_d) : stage_d;
        dout_o = word_i ? {{(W-HW){raw_d[HW-1]}}, raw_d[HW-1:0]} : raw_d;

        // A zero shift amount must pass the source through unchanged.
        if (sh_d == '0) begin
            p_shift_zero_r6: assert (dout_o == (word_i ?
                    {{(W-HW){src_i[HW-1]}}, src_i[HW-1:0]} : src_i))
                else $error("zero shift altered the source");
        end
        // A full-width arithmetic right shift keeps the sign bit.
        if (arith_i && !left_i && !word_i) begin
            p_sra_sign_r7: assert (dout_o[W-1] == src_i[W-1])
                else $error("arithmetic shift lost the sign");
        end
    end

endmodule

// File: rtl/alu_bitcmp.sv
module alu_bitcmp
    import alu_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  alu_f3_e      f3_i,
    output logic [W-1:0] dout_o
);

    logic lts_d;
    logic ltu_d;

    always_comb begin
        lts_d = $signed(a_i) < $signed(b_i);
        ltu_d = a_i < b_i;
        case (f3_i)
            F3_SLT:  dout_o = {{(W-1){1'b0}}, lts_d};
            F3_SLTU: dout_o = {{(W-1){1'b0}}, ltu_d};
            F3_XOR:  dout_o = a_i ^ b_i;
            F3_OR:   dout_o = a_i | b_i;
            F3_AND:  dout_o = a_i & b_i;
            default: dout_o = '0;
        endcase

        // Strict ordering: less-than never holds for equal operands.
        p_slt_strict_r4: assert (!lts_d || (a_i != b_i))
            else $error("signed less-than on equal operands");
        // A negative A against a non-negative B is always less, signed.
        p_slt_sign_r4: assert (!(a_i[W-1] && !b_i[W-1]) || lts_d)
            else $error("signed compare ignored sign");
        // Nothing is unsigned-less than zero.
        p_sltu_zero_r5: assert (!ltu_d || (b_i != '0))
            else $error("unsigned less-than zero");
    end

endmodule

// File: rtl/int_alu64.sv
module int_alu64
    import alu_pkg::*;
#(
    parameter int W  = ALU_XLEN,
    parameter int HW = ALU_WLEN,
    localparam int SHW = $clog2(W)
) (
    input  logic [W-1:0] op_a_i,
    input  logic [W-1:0] op_b_i,
    input  logic [2:0]   funct3_i,
    input  logic         alt_i,
    input  logic         word_i,
    output logic [W-1:0] result_o,
    output logic         illegal_o
);

    alu_f3_e  f3;
    logic     is_sll;
    logic     is_sr;
    logic [W-1:0] add_res;
    logic [W-1:0] sh_res;
    logic [W-1:0] bc_res;
    alu_out_t out_d;

    assign f3     = alu_f3_e'(funct3_i);
    assign is_sll = (f3 == F3_SLL);
    assign is_sr  = (f3 == F3_SR);

    alu_addsub #(.W(W), .HW(HW)) addsub_i (
        .a_i    (op_a_i),
        .b_i    (op_b_i),
        .sub_i  (alt_i),
        .word_i (word_i),
        .sum_o  (add_res)
    );

    alu_shift #(.W(W), .HW(HW)) shift_i (
        .src_i   (op_a_i),
        .shamt_i (op_b_i[SHW-1:0]),
        .left_i  (is_sll),
        .arith_i (alt_i && is_sr),
        .word_i  (word_i),
        .dout_o  (sh_res)
    );

    alu_bitcmp #(.W(W)) bitcmp_i (
        .a_i    (op_a_i),
        .b_i    (op_b_i),
        .f3_i   (f3),
        .dout_o (bc_res)
    );

    always_comb begin
        out_d.ill = word_i && !(f3 inside {F3_ADD, F3_SLL, F3_SR});
        if (out_d.ill)             out_d.res = '0;
        else if (f3 == F3_ADD)     out_d.res = add_res;
        else if (is_sll || is_sr)  out_d.res = sh_res;
        else                       out_d.res = bc_res;
    end

    assign result_o  = out_d.res;
    assign illegal_o = out_d.ill;

endmodule

// File: tb/int_alu64_tb_top.sv
module int_alu64_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] a, b;
    logic [2:0]  f3;
    logic        alt, w;
    logic [63:0] res;
    logic        ill;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done  = 1'b0;

    typedef struct {
        logic [63:0] exp_res;
        logic        exp_ill;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #5 clk = ~clk;

    int_alu64 dut_i (
        .op_a_i(a), .op_b_i(b), .funct3_i(f3), .alt_i(alt), .word_i(w),
        .result_o(res), .illegal_o(ill)
    );

    function automatic logic [63:0] sx32(input logic [31:0] v);
        return {{32{v[31]}}, v};
    endfunction

    function automatic logic [64:0] model(input logic [63:0] ma, input logic [63:0] mb,
                                          input logic [2:0] mf, input logic malt,
                                          input logic mw);
        logic [31:0] t;
        if (mw) begin
            case (mf)
                3'b000: begin t = malt ? ma[31:0] - mb[31:0] : ma[31:0] + mb[31:0];
                              return {1'b0, sx32(t)}; end
                3'b001: begin t = ma[31:0] << mb[4:0]; return {1'b0, sx32(t)}; end
                3'b101: begin
                    t = malt ? 32'($signed(ma[31:0]) >>> mb[4:0]) : ma[31:0] >> mb[4:0];
                    return {1'b0, sx32(t)};
                end
                default: return {1'b1, 64'd0};
            endcase
        end
        case (mf)
            3'b000: return {1'b0, malt ? ma - mb : ma + mb};
            3'b001: return {1'b0, ma << mb[5:0]};
            3'b010: return {1'b0, 63'd0, $signed(ma) < $signed(mb)};
            3'b011: return {1'b0, 63'd0, ma < mb};
            3'b100: return {1'b0, ma ^ mb};
            3'b101: return {1'b0, malt ? 64'($signed(ma) >>> mb[5:0]) : ma >> mb[5:0]};
            3'b110: return {1'b0, ma | mb};
            default: return {1'b0, ma & mb};
        endcase
    endfunction

    function automatic string auto_tag(input logic [2:0] mf, input logic malt, input logic mw);
        if (mw) begin
            if (mf == 3'b000) return "R8";
            if (mf == 3'b001 || mf == 3'b101) return "R9";
            return "R10";
        end
        case (mf)
            3'b000: return malt ? "R2" : "R1";
            3'b001: return "R6";
            3'b010: return "R4";
            3'b011: return "R5";
            3'b101: return "R7";
            default: return "R3";
        endcase
    endfunction

    task automatic apply(input logic [63:0] ta, input logic [63:0] tb,
                         input logic [2:0] tf, input logic talt, input logic tw,
                         input string tag);
        item_t it;
        logic [64:0] m;
        @(posedge clk);
        #1;
        a = ta; b = tb; f3 = tf; alt = talt; w = tw;
        m = model(ta, tb, tf, talt, tw);
        it.exp_ill = m[64];
        it.exp_res = m[63:0];
        it.tag     = (tag == "") ? auto_tag(tf, talt, tw) : tag;
        sb_q.push_back(it);
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    // Monitor: compares at the falling edge, away from input changes.
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                n_cmp++;
                if (res !== it.exp_res || ill !== it.exp_ill) begin
                    n_bad++;
                    $display("FAIL %s: got res=%h ill=%b expected res=%h ill=%b",
                             it.tag, res, ill, it.exp_res, it.exp_ill);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        a = '0; b = '0; f3 = '0; alt = 1'b0; w = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Idle state: zero operands give zero and no illegal flag (R1, R10)
        apply(64'd0, 64'd0, 3'b000, 1'b0, 1'b0, "R1");
        // R1 wrap
        apply(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 3'b000, 1'b0, 1'b0, "R1");
        apply(64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 3'b000, 1'b0, 1'b0, "R1");
        // R2 wrap
        apply(64'h8000_0000_0000_0000, 64'd1, 3'b000, 1'b1, 1'b0, "R2");
        apply(64'd0, 64'd1, 3'b000, 1'b1, 1'b0, "R2");
        // R3
        apply(64'hF0F0_1234_5678_9ABC, 64'h0FF0_FFFF_0000_1111, 3'b100, 1'b0, 1'b0, "R3");
        apply(64'hF0F0_1234_5678_9ABC, 64'h0FF0_FFFF_0000_1111, 3'b110, 1'b0, 1'b0, "R3");
        apply(64'hF0F0_1234_5678_9ABC, 64'h0FF0_FFFF_0000_1111, 3'b111, 1'b0, 1'b0, "R3");
        // R4 / R5: sign split, equal operands
        apply(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 3'b010, 1'b0, 1'b0, "R4");
        apply(64'd5, 64'd5, 3'b010, 1'b0, 1'b0, "R4");
        apply(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 3'b011, 1'b0, 1'b0, "R5");
        apply(64'd1, 64'hFFFF_FFFF_FFFF_F800, 3'b011, 1'b0, 1'b0, "R5");
        // R6 / R7 with garbage high bits in B
        apply(64'h0000_0000_0000_0001, 64'hABCD_0000_0000_007F, 3'b001, 1'b0, 1'b0, "R6");
        apply(64'h8000_0000_0000_0000, 64'h1234_0000_0000_0043, 3'b101, 1'b1, 1'b0, "R7");
        apply(64'h8000_0000_0000_0000, 64'h1234_0000_0000_0043, 3'b101, 1'b0, 1'b0, "R7");
        // R8 word add/sub sign extension
        apply(64'h1234_5678_7FFF_FFFF, 64'd1, 3'b000, 1'b0, 1'b1, "R8");
        apply(64'hFFFF_FFFF_0000_0000, 64'd1, 3'b000, 1'b1, 1'b1, "R8");
        // R9 word sra fills from bit 31 (bit 63 clear), only 5 amount bits
        apply(64'h0000_0000_8000_0000, 64'h0000_0000_0000_0024, 3'b101, 1'b1, 1'b1, "R9");
        apply(64'hFFFF_FFFF_8000_0000, 64'd4, 3'b101, 1'b0, 1'b1, "R9");
        apply(64'h0000_0000_0000_0001, 64'd31, 3'b001, 1'b0, 1'b1, "R9");
        // R10 illegal word ops
        apply(64'hFFFF, 64'h1, 3'b010, 1'b0, 1'b1, "R10");
        apply(64'hFFFF, 64'h1, 3'b111, 1'b0, 1'b1, "R10");
        apply(64'hFFFF, 64'h1, 3'b100, 1'b1, 1'b1, "R10");
        // R11 alternate bit ignored
        apply(64'h0000_0000_0000_0003, 64'd4, 3'b001, 1'b1, 1'b0, "R11");
        apply(64'hFFFF_FFFF_FFFF_FFFE, 64'd3, 3'b010, 1'b1, 1'b0, "R11");
        apply(64'hFFFF_FFFF_FFFF_FFFE, 64'd3, 3'b011, 1'b1, 1'b0, "R11");
        apply(64'hAAAA_5555_AAAA_5555, 64'h0F0F, 3'b100, 1'b1, 1'b0, "R11");
        apply(64'hAAAA_5555_AAAA_5555, 64'h0F0F, 3'b110, 1'b1, 1'b0, "R11");
        apply(64'hAAAA_5555_AAAA_5555, 64'h0F0F, 3'b111, 1'b1, 1'b0, "R11");
        // Sweep every shift amount with sign bits 31 and 63 disagreeing
        for (int s = 0; s < 64; s++) begin
            logic [63:0] hb;
            hb = {$urandom, 32'd0} & 64'hFFFF_FFFF_FFFF_FFC0;
            apply(64'h4321_0FED_8765_4321, hb | 64'(s), 3'b001, 1'b0, 1'b0, "");
            apply(64'h4321_0FED_8765_4321, hb | 64'(s), 3'b101, 1'b0, 1'b0, "");
            apply(64'hC321_0FED_7765_4321, hb | 64'(s), 3'b101, 1'b1, 1'b0, "");
            apply(64'h4321_0FED_8765_4321, hb | 64'(s), 3'b001, 1'b0, 1'b1, "");
            apply(64'h4321_0FED_8765_4321, hb | 64'(s), 3'b101, 1'b0, 1'b1, "");
            apply(64'h4321_0FED_8765_4321, hb | 64'(s), 3'b101, 1'b1, 1'b1, "");
        end
        // Random run over all operations
        for (int i = 0; i < 4000; i++) begin
            logic [2:0] rf;
            logic       ralt, rw;
            rf   = 3'($urandom);
            ralt = 1'($urandom);
            rw   = 1'($urandom);
            apply(rnd64(), rnd64(), rf, ralt, rw, "");
        end
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule